// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital controller of a 10-bit successive-approximation analog-to-digital converter. Software starts a conversion by writing the start/busy bit through a single control-write port. The sequencer opens the sample-and-hold switch so that the held voltage no longer follows the input. It then resolves one result bit per conversion-clock period, from the most significant bit down to the least. During each period it drives a trial code to an external DAC and reads one comparator bit. The conversion clock is a tick derived from the system clock by a selectable divide ratio.

When the last bit is decided, several things happen on one clock edge. The result is packed into a high and a low byte, left or right justified as chosen at start. The busy bit drops, a sticky completion flag sets, and the sampler closes again. The interrupt request is the completion flag gated by an enable. While the system sleeps, the same request also drives a wake output. Writing the start bit to zero during a conversion abandons it.

The states are `ST_IDLE` (sampler closed, waiting), `ST_HOLD` (one setup period with the sampler open) and `ST_BITS` (one bit decision per tick). The transitions are:
- start: `ST_IDLE` to `ST_HOLD` on a write with start = 1.
- setup done: `ST_HOLD` to `ST_BITS` on a tick.
- finish: `ST_BITS` to `ST_IDLE` on the tick that decides bit 0.
- abort: `ST_HOLD` or `ST_BITS` to `ST_IDLE` on a write with start = 0.

Top module: `sar_conv_seq`

## Requirements
- R1: A control write with start = 1 while idle raises `busy` and drops `sample_connect` on the next clock edge. The divide select and the format select are captured on that same write.
- R2: A conversion lasts exactly 11 conversion periods of D system clocks each. D is 2 for divide select 0, 8 for 1, and 32 for 2 or 3. Completion therefore falls 11·D clocks after the start write.
- R3: Period 1 is setup, with `dac_code` = 0. Each later period drives a code that keeps the bits already decided, sets the current bit and clears all lower bits. The first bit period drives 0x200. At the end of each period the current bit is kept when `cmp_in` = 1 (input ≥ DAC) and cleared otherwise.
- R4: With format select 0 (left justified), `res_hi` = result[9:2], `res_lo`[7:6] = result[1:0] and `res_lo`[5:0] = 0.
- R5: With format select 1 (right justified), `res_lo` = result[7:0], `res_hi`[1:0] = result[9:8] and `res_hi`[7:2] = 0.
- R6: At completion, on a single edge, both result bytes load, `busy` clears, `done_flag` sets and `sample_connect` returns to 1. After reset the block is idle with `sample_connect` = 1 and the results and flag at 0.
- R7: `done_flag` sets on every completion whatever the value of `int_en`. Only a `flag_clr` pulse clears it, and a completion in the same cycle takes precedence.
- R8: `irq` = `done_flag` AND `int_en`, and `wake` = `irq` AND `sleep_mode`.
- R9: A write with start = 0 during a conversion aborts it. On the next edge `busy` = 0 and `sample_connect` = 1, the result bytes are unchanged and `done_flag` is not set.
- R10: The result bytes change only at completion, so a read during a conversion returns the previous result.
- R11: A write with start = 1 during a conversion is ignored. The timing and the format of the running conversion stay as they were.
- R12: The result is the code of the voltage held when the sampler opened. Input changes during the conversion have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_start | input | 1 | Start/busy bit value written |
| ctl_fmt | input | 1 | Justification written (0 left, 1 right) |
| ctl_div | input | 2 | Conversion clock divide select written |
| flag_clr | input | 1 | Software clear of the completion flag |
| int_en | input | 1 | Completion interrupt enable |
| sleep_mode | input | 1 | System is sleeping |
| cmp_in | input | 1 | Comparator: 1 when held input ≥ DAC output |
| dac_code | output | 10 | Trial code driven to the DAC |
| sample_connect | output | 1 | 1 closes the sampling switch |
| busy | output | 1 | Start/busy bit read-back |
| res_hi | output | 8 | High result byte |
| res_lo | output | 8 | Low result byte |
| done_flag | output | 1 | Sticky completion flag |
| irq | output | 1 | Interrupt request |
| wake | output | 1 | Wake-up request |

## Verification
Assertions check the following on every cycle:
- the zero padding left by each justification;
- that the result bytes hold still except at completion;
- that the flag stays sticky and sets with the completion edge;
- that `busy` rises only on a start write;
- that the divider counter stays within range;
- that `wake` is never raised without sleep and enable.

The bench scenarios cover what a property cannot see: the exact 11·D frame length for each divide ratio, the trial code in successive periods, that the result equals the held voltage even when the live input moves, aborts, and start writes that are ignored.

// File: rtl/sar_pkg.sv
package sar_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HOLD = 2'd1,
        ST_BITS = 2'd2
    } sar_state_e;

    localparam int unsigned SEL_W = 2;
endpackage

// File: rtl/sar_tick_gen.sv
module sar_tick_gen #(
    parameter int unsigned DIV_A = 2,
    parameter int unsigned DIV_B = 8,
    parameter int unsigned DIV_C = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [1:0] sel,
    output logic       tick
);
    localparam int unsigned MAXD  = (DIV_A > DIV_B) ? ((DIV_A > DIV_C) ? DIV_A : DIV_C)
                                                    : ((DIV_B > DIV_C) ? DIV_B : DIV_C);
    localparam int unsigned CNT_W = $clog2(MAXD);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last;

    always_comb begin
        unique case (sel)
            2'd0:    last = CNT_W'(DIV_A - 1);
            2'd1:    last = CNT_W'(DIV_B - 1);
            default: last = CNT_W'(DIV_C - 1);
        endcase
    end

    assign tick = run && (cnt_q == last);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (!run)   cnt_q <= '0;
        else if (tick)   cnt_q <= '0;
        else             cnt_q <= cnt_q + 1'b1;
    end

    AST_TICK_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q <= last)); // R2
endmodule

// File: rtl/sar_result_pack.sv
module sar_result_pack #(
    parameter int unsigned RES_W  = 10,
    parameter int unsigned BYTE_W = 8
) (
    input  logic [RES_W-1:0]  code,
    input  logic              right_just,
    output logic [BYTE_W-1:0] hi,
    output logic [BYTE_W-1:0] lo
);
    localparam int unsigned WORD_W = 2 * BYTE_W;
    localparam int unsigned PAD_W  = WORD_W - RES_W;

    logic [WORD_W-1:0] word;

    always_comb begin
        if (right_just) word = {{PAD_W{1'b0}}, code};
        else            word = {code, {PAD_W{1'b0}}};
        hi = word[WORD_W-1:BYTE_W];
        lo = word[BYTE_W-1:0];
    end
endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq
    import sar_pkg::*;
#(
    parameter int unsigned RES_W  = 10,
    parameter int unsigned BYTE_W = 8,
    parameter int unsigned DIV_A  = 2,
    parameter int unsigned DIV_B  = 8,
    parameter int unsigned DIV_C  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_we,
    input  logic              ctl_start,
    input  logic              ctl_fmt,
    input  logic [1:0]        ctl_div,
    input  logic              flag_clr,
    input  logic              int_en,
    input  logic              sleep_mode,
    input  logic              cmp_in,
    output logic [RES_W-1:0]  dac_code,
    output logic              sample_connect,
    output logic              busy,
    output logic [BYTE_W-1:0] res_hi,
    output logic [BYTE_W-1:0] res_lo,
    output logic              done_flag,
    output logic              irq,
    output logic              wake
);
    localparam int unsigned IDX_W = $clog2(RES_W);
    localparam int unsigned PAD_W = 2 * BYTE_W - RES_W;

    sar_state_e        state_q, state_d;
    logic [RES_W-1:0]  trial_q, decided;
    logic [IDX_W-1:0]  idx_q;
    logic              fmt_q;
    logic [SEL_W-1:0]  div_q;
    logic [BYTE_W-1:0] hi_q, lo_q, hi_pk, lo_pk;
    logic              flag_q;
    logic              tick, run;
    logic              start_req, abort_req, last_bit, done_pulse;

    assign start_req  = ctl_we && ctl_start;
    assign abort_req  = ctl_we && !ctl_start && (state_q != ST_IDLE);
    assign last_bit   = (idx_q == '0);
    assign run        = (state_q != ST_IDLE);
    assign done_pulse = (state_q == ST_BITS) && tick && last_bit && !abort_req;

    sar_tick_gen #(.DIV_A(DIV_A), .DIV_B(DIV_B), .DIV_C(DIV_C)) u_tick (
        .clk(clk), .rst_n(rst_n), .run(run), .sel(div_q), .tick(tick)
    );

    always_comb begin
        decided = trial_q;
        if (!cmp_in) decided[idx_q] = 1'b0;
    end

    sar_result_pack #(.RES_W(RES_W), .BYTE_W(BYTE_W)) u_pack (
        .code(decided), .right_just(fmt_q), .hi(hi_pk), .lo(lo_pk)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_req) state_d = ST_HOLD;
            ST_HOLD: begin
                if (abort_req)  state_d = ST_IDLE;
                else if (tick)  state_d = ST_BITS;
            end
            ST_BITS: begin
                if (abort_req)              state_d = ST_IDLE;
                else if (tick && last_bit)  state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trial_q <= '0;
            idx_q   <= '0;
            fmt_q   <= 1'b0;
            div_q   <= '0;
            hi_q    <= '0;
            lo_q    <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start_req) begin
                    fmt_q   <= ctl_fmt;
                    div_q   <= ctl_div;
                    trial_q <= '0;
                end
                ST_HOLD: if (tick && !abort_req) begin
                    trial_q <= '0;
                    trial_q[RES_W-1] <= 1'b1;
                    idx_q   <= IDX_W'(RES_W - 1);
                end
                ST_BITS: if (tick && !abort_req) begin
                    if (last_bit) begin
                        trial_q <= decided;
                        hi_q    <= hi_pk;
                        lo_q    <= lo_pk;
                    end else begin
                        trial_q <= decided | (RES_W'(1) << (idx_q - 1'b1));
                        idx_q   <= idx_q - 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // sticky completion flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          flag_q <= 1'b0;
        else if (done_pulse) flag_q <= 1'b1;
        else if (flag_clr)   flag_q <= 1'b0;
    end

    // output process
    always_comb begin
        busy           = (state_q != ST_IDLE);
        sample_connect = (state_q == ST_IDLE);
        dac_code       = trial_q;
        res_hi         = hi_q;
        res_lo         = lo_q;
        done_flag      = flag_q;
        irq            = flag_q && int_en;
        wake           = irq && sleep_mode;
    end

    AST_BUSY_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(ctl_we && ctl_start)); // R1
    AST_LEFT_PAD: assert property (@(posedge clk) disable iff (!rst_n)
        (done_pulse && !fmt_q) |=> (res_lo[PAD_W-1:0] == '0)); // R4
    AST_RIGHT_PAD: assert property (@(posedge clk) disable iff (!rst_n)
        (done_pulse && fmt_q) |=> (res_hi[BYTE_W-1:BYTE_W-PAD_W] == '0)); // R5
    AST_DONE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> (done_flag && !busy && sample_connect)); // R6
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (done_flag && !flag_clr) |=> done_flag); // R7
    AST_WAKE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> (sleep_mode && int_en && done_flag)); // R8
    AST_RES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done_pulse |=> ($stable(res_hi) && $stable(res_lo))); // R10
endmodule

// File: tb/sar_conv_seq_test.sv
module sar_conv_seq_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_we = 1'b0, ctl_start = 1'b0, ctl_fmt = 1'b0;
    logic [1:0] ctl_div = 2'd0;
    logic       flag_clr = 1'b0, int_en = 1'b0, sleep_mode = 1'b0;
    logic       cmp_in;
    logic [9:0] dac_code;
    logic       sample_connect, busy, done_flag, irq, wake;
    logic [7:0] res_hi, res_lo;

    logic [9:0] vin_live = 10'd0;
    logic [9:0] vheld = 10'd0;
    int checks = 0;
    int errors = 0;
    logic [15:0] exp_q[$];
    logic mon_prev_busy = 1'b0;

    always #5 clk = ~clk;

    // analog model: the capacitor follows the input only while connected
    always @(sample_connect or vin_live) if (sample_connect) vheld = vin_live;
    assign cmp_in = (vheld >= dac_code);

    sar_conv_seq uut (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_start(ctl_start),
        .ctl_fmt(ctl_fmt), .ctl_div(ctl_div), .flag_clr(flag_clr),
        .int_en(int_en), .sleep_mode(sleep_mode), .cmp_in(cmp_in),
        .dac_code(dac_code), .sample_connect(sample_connect), .busy(busy),
        .res_hi(res_hi), .res_lo(res_lo), .done_flag(done_flag),
        .irq(irq), .wake(wake)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] packed_exp(input logic [9:0] v, input logic fmt);
        if (fmt) return {6'b0, v};
        else     return {v, 6'b0};
    endfunction

    function automatic int div_of(input logic [1:0] d);
        return (d == 2'd0) ? 2 : (d == 2'd1) ? 8 : 32;
    endfunction

    task automatic wr(input logic st, input logic fmt, input logic [1:0] dv);
        @(negedge clk);
        ctl_we = 1'b1; ctl_start = st; ctl_fmt = fmt; ctl_div = dv;
        @(negedge clk);
        ctl_we = 1'b0;
    endtask

    task automatic pulse_clr();
        @(negedge clk); flag_clr = 1'b1;
        @(negedge clk); flag_clr = 1'b0;
    endtask

    // driver: pushes the expected result, starts, times the frame
    task automatic convert(input logic [9:0] v, input logic fmt, input logic [1:0] dv);
        int cnt = 0;
        vin_live = v;
        exp_q.push_back(packed_exp(v, fmt));
        wr(1'b1, fmt, dv);
        chk("R1 busy after start", {sample_connect, busy}, 2'b01);
        while (busy) begin @(negedge clk); cnt++; end
        chk("R2 frame length", cnt, 11 * div_of(dv));
    endtask

    // monitor: pops and compares on every completion
    always @(negedge clk) begin
        if (mon_prev_busy && !busy && exp_q.size() > 0) begin
            logic [15:0] e;
            e = exp_q.pop_front();
            chk("R4/R5 result bytes", {res_hi, res_lo}, e);
            chk("R6 completion edge", {done_flag, sample_connect}, 2'b11);
        end
        mon_prev_busy = busy;
    end

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R6 reset state", {busy, sample_connect, done_flag, res_hi, res_lo}, {1'b0, 1'b1, 1'b0, 16'h0});

        convert(10'h2A5, 1'b0, 2'd0);   // R4 left, D=2
        chk("R7 flag set with int_en=0", done_flag, 1'b1);
        convert(10'h2A5, 1'b1, 2'd1);   // R5 right, D=8
        convert(10'h000, 1'b1, 2'd0);
        convert(10'h3FF, 1'b0, 2'd2);   // D=32
        convert(10'h155, 1'b1, 2'd3);   // select 3 also 32

        // R3 trial codes, R10 old result visible, R12 held voltage
        begin
            int cnt = 0;
            vin_live = 10'h2A5;
            exp_q.push_back(packed_exp(10'h2A5, 1'b0));
            wr(1'b1, 1'b0, 2'd1);
            chk("R3 setup code", dac_code, 10'h000);
            repeat (8) @(negedge clk);
            chk("R3 first bit trial", dac_code, 10'h200);
            vin_live = 10'h011;
            repeat (8) @(negedge clk);
            chk("R3 second bit trial", dac_code, 10'h300);
            chk("R10 previous result", {res_hi, res_lo}, packed_exp(10'h155, 1'b1));
            while (busy) @(negedge clk);
            chk("R12 held result", {res_hi, res_lo}, packed_exp(10'h2A5, 1'b0));
        end

        // R7 clear, R8 irq/wake
        pulse_clr();
        chk("R7 cleared by software", done_flag, 1'b0);
        vin_live = 10'h0F0;
        convert(10'h0F0, 1'b0, 2'd0);
        int_en = 1'b1; sleep_mode = 1'b0;
        @(negedge clk);
        chk("R8 irq awake", {irq, wake}, 2'b10);
        sleep_mode = 1'b1;
        @(negedge clk);
        chk("R8 wake asleep", {irq, wake}, 2'b11);
        int_en = 1'b0;
        @(negedge clk);
        chk("R8 disabled", {irq, wake, done_flag}, 3'b001);
        sleep_mode = 1'b0;
        pulse_clr();

        // R9 abort
        vin_live = 10'h005;
        wr(1'b1, 1'b1, 2'd1);
        repeat (20) @(negedge clk);
        wr(1'b0, 1'b1, 2'd1);
        chk("R9 abort idle", {busy, sample_connect}, 2'b01);
        repeat (10) @(negedge clk);
        chk("R9 no flag, results kept", {done_flag, res_hi, res_lo}, {1'b0, packed_exp(10'h0F0, 1'b0)});

        // R11 start while busy ignored
        begin
            int cnt = 0;
            vin_live = 10'h1C3;
            exp_q.push_back(packed_exp(10'h1C3, 1'b0));
            wr(1'b1, 1'b0, 2'd0);
            repeat (5) begin @(negedge clk); cnt++; end
            wr(1'b1, 1'b1, 2'd2);
            cnt += 2;
            while (busy) begin @(negedge clk); cnt++; end
            chk("R11 frame unchanged", cnt, 22);
            chk("R11 format unchanged", {res_hi, res_lo}, packed_exp(10'h1C3, 1'b0));
        end

        repeat (4) @(negedge clk);
        chk("scoreboard drained", exp_q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule